// File: doc/BRIEF.md
# Write-Protection Status Register Unit

This unit holds the one-byte protection status register of a small serial nonvolatile memory and decides, every cycle, whether a memory byte write or a status write may go ahead. The command decoder in front of it gives it single-cycle pulses: arm writes, disarm writes, load the status register (with the byte to load), commit one memory byte at a given address, and chip-select release. It also sees the active-low hardware protect pin. It returns the status byte for reads, a permit for a memory write to the address on its address input, and a permit for a status write. The register lives in flip-flops. Nonvolatile storage, serial shifting and opcode decoding belong to the neighbouring blocks.

Protection works in three tiers. The first tier is a write-enable latch. The second is a pair of block-protect bits that fence off the top quarter, the top half or all of the 2048-byte space. The third is the hardware pin, which guards the status register only while the status pin-enable bit is set.

The latch is a three-state machine. The states are LOCKED (latch clear), ARMED (latch set, nothing written yet) and SPENT (latch set, at least one permitted write done during the current select). The transitions are:
- arm: LOCKED to ARMED, on an arm pulse without a disarm pulse.
- disarm: ARMED or SPENT to LOCKED, on a disarm pulse.
- commit: ARMED to SPENT, on a permitted status load or memory write.
- close: SPENT to LOCKED, on chip-select release. A release seen in the same cycle as a commit in ARMED also goes straight to LOCKED.

The latch bit reads as 1 in both ARMED and SPENT. A burst of sequential bytes inside one select therefore keeps its permission until the select ends.

Top module: `srwp_unit`

## Requirements
- R1: After reset the status byte is 8'h00, and both permits are 0.
- R2: An arm pulse sets the latch bit (status bit 1) at the next clock.
- R3: A disarm pulse clears the latch bit at the next clock. It wins over an arm pulse given in the same cycle.
- R4: Status bits 0, 4, 5 and 6 always read 0, whatever byte is loaded.
- R5: A permitted status load copies data bit 7 into the pin-enable bit and data bits 3:2 into the block-protect code. Data bit 1 has no effect on the latch.
- R6: A status load while the latch bit is 0 is refused (status permit 0), and the status byte stays unchanged.
- R7: With pin-enable (bit 7) at 1 and the protect pin low, the status permit is 0 and a load leaves the register unchanged. With pin-enable at 0, the pin does not affect the status permit.
- R8: The memory permit is 0 for protected addresses, decided from the 11 address bits. Block-protect code 00 protects nothing, 01 protects 0x600–0x7FF, 10 protects 0x400–0x7FF, and 11 protects 0x000–0x7FF.
- R9: The memory permit requires the latch bit at 1, and the protect pin never affects it.
- R10: After a permitted write, the latch stays set through further bytes of the same select. It clears at the clock on which chip-select release is signalled.
- R11: A refused write (memory or status) leaves the latch set, and a later chip-select release does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_pulse | input | 1 | Set-write-enable command pulse |
| disarm_pulse | input | 1 | Clear-write-enable command pulse |
| sr_load_pulse | input | 1 | Status-register write command pulse |
| sr_load_byte | input | 8 | Byte offered with the status write |
| mem_wr_pulse | input | 1 | One memory byte is being committed |
| mem_addr | input | 11 | Target address of the memory byte |
| cs_release | input | 1 | Chip select went inactive (end of operation) |
| wp_n | input | 1 | Hardware protect pin, active low |
| status_byte | output | 8 | Current status register value |
| mem_wr_ok | output | 1 | Memory write to mem_addr is permitted |
| sr_wr_ok | output | 1 | Status write is permitted |

## Verification
The hardest case to reach is a refused write that sits between an arm and a release. From the ports, that looks just like a latch that was never used, because the latch bit reads the same in ARMED and SPENT. The stimulus therefore arms the latch and then tries writes that the protect pin or the block fence must refuse. It releases chip select and checks that the latch bit survives. It then contrasts this with a permitted write, where the same release clears the latch.

// File: rtl/srwp_pkg.sv
package srwp_pkg;

    typedef enum logic [1:0] {
        WEL_LOCKED = 2'd0,
        WEL_ARMED  = 2'd1,
        WEL_SPENT  = 2'd2
    } wel_state_t;

    localparam int SR_W       = 8;
    localparam int BIT_PINEN  = 7;
    localparam int BIT_BP_HI  = 3;
    localparam int BIT_BP_LO  = 2;
    localparam int BIT_LATCH  = 1;

    typedef enum logic [1:0] {
        FENCE_NONE    = 2'b00,
        FENCE_QUARTER = 2'b01,
        FENCE_HALF    = 2'b10,
        FENCE_ALL     = 2'b11
    } fence_t;

endpackage

// File: rtl/srwp_latch_fsm.sv
module srwp_latch_fsm
    import srwp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic disarm,
    input  logic commit,
    input  logic close,
    output logic latch
);

    wel_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WEL_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WEL_LOCKED: begin
                if (arm && !disarm) state_d = WEL_ARMED;
            end
            WEL_ARMED: begin
                if (disarm)                state_d = WEL_LOCKED;
                else if (commit && close)  state_d = WEL_LOCKED;
                else if (commit)           state_d = WEL_SPENT;
            end
            WEL_SPENT: begin
                if (disarm || close) state_d = WEL_LOCKED;
            end
            default: state_d = WEL_LOCKED;
        endcase
    end

    always_comb begin
        latch = (state_q == WEL_ARMED) || (state_q == WEL_SPENT);
    end

endmodule

// File: rtl/srwp_cfg_reg.sv
module srwp_cfg_reg
    import srwp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SR_W-1:0] load_byte,
    output logic            pin_en,
    output logic [1:0]      fence
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_en <= 1'b0;
            fence  <= 2'b00;
        end else if (load) begin
            pin_en <= load_byte[BIT_PINEN];
            fence  <= load_byte[BIT_BP_HI:BIT_BP_LO];
        end
    end

endmodule

// File: rtl/srwp_block_guard.sv
module srwp_block_guard
    import srwp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        fence,
    input  logic [ADDR_W-1:0] addr,
    output logic              fenced
);

    localparam int TOP_BITS = 2;

    logic [TOP_BITS-1:0] top;
    logic [3:0]          hit;

    assign top = addr[ADDR_W-1 -: TOP_BITS];

    genvar c;
    generate
        for (c = 0; c < 4; c++) begin : g_code
            if (c == 0) begin : g_none
                assign hit[c] = 1'b0;
            end else if (c == 1) begin : g_quarter
                assign hit[c] = (top == 2'b11);
            end else if (c == 2) begin : g_half
                assign hit[c] = top[TOP_BITS-1];
            end else begin : g_all
                assign hit[c] = 1'b1;
            end
        end
    endgenerate

    always_comb begin
        fenced = hit[fence];
    end

endmodule

// File: rtl/srwp_unit.sv
module srwp_unit
    import srwp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_pulse,
    input  logic              disarm_pulse,
    input  logic              sr_load_pulse,
    input  logic [7:0]        sr_load_byte,
    input  logic              mem_wr_pulse,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              cs_release,
    input  logic              wp_n,
    output logic [7:0]        status_byte,
    output logic              mem_wr_ok,
    output logic              sr_wr_ok
);

    logic       latch;
    logic       pin_en;
    logic [1:0] fence;
    logic       fenced;
    logic       commit;

    srwp_latch_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm_pulse),
        .disarm (disarm_pulse),
        .commit (commit),
        .close  (cs_release),
        .latch  (latch)
    );

    srwp_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sr_load_pulse && sr_wr_ok),
        .load_byte (sr_load_byte),
        .pin_en    (pin_en),
        .fence     (fence)
    );

    srwp_block_guard #(.ADDR_W(ADDR_W)) u_guard (
        .fence  (fence),
        .addr   (mem_addr),
        .fenced (fenced)
    );

    always_comb begin
        sr_wr_ok  = latch && !(pin_en && !wp_n);
        mem_wr_ok = latch && !fenced;
        commit    = (sr_load_pulse && sr_wr_ok) || (mem_wr_pulse && mem_wr_ok);

        status_byte            = '0;
        status_byte[BIT_PINEN] = pin_en;
        status_byte[BIT_BP_HI] = fence[1];
        status_byte[BIT_BP_LO] = fence[0];
        status_byte[BIT_LATCH] = latch;
    end

endmodule

// File: rtl/srwp_unit_chk.sv
module srwp_unit_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm_pulse,
    input logic              disarm_pulse,
    input logic              sr_load_pulse,
    input logic [7:0]        sr_load_byte,
    input logic              mem_wr_pulse,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              cs_release,
    input logic              wp_n,
    input logic [7:0]        status_byte,
    input logic              mem_wr_ok,
    input logic              sr_wr_ok
);

    // R4
    fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte & 8'h71) == 8'h00);

    // R2
    arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_pulse && !disarm_pulse) |=> status_byte[1]);

    // R3
    disarm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_pulse |=> !status_byte[1]);

    // R9
    latch_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_byte[1] |-> (!mem_wr_ok && !sr_wr_ok));

    // R6
    refused_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_load_pulse && !sr_wr_ok && !arm_pulse && !disarm_pulse)
            |=> $stable(status_byte[7:2]));

    // R7
    pin_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[7] && !wp_n) |-> !sr_wr_ok);

    // R8
    fence_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[3:2] == 2'b11) |-> !mem_wr_ok);

    // R5
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_load_pulse && sr_wr_ok) |=>
            (status_byte[7] == $past(sr_load_byte[7]) &&
             status_byte[3:2] == $past(sr_load_byte[3:2])));

endmodule

bind srwp_unit srwp_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/srwp_unit_tb.sv
`timescale 1ns/1ps
module srwp_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_pulse = 1'b0;
    logic        disarm_pulse = 1'b0;
    logic        sr_load_pulse = 1'b0;
    logic [7:0]  sr_load_byte = 8'h00;
    logic        mem_wr_pulse = 1'b0;
    logic [10:0] mem_addr = 11'h000;
    logic        cs_release = 1'b0;
    logic        wp_n = 1'b1;
    logic [7:0]  status_byte;
    logic        mem_wr_ok;
    logic        sr_wr_ok;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    srwp_unit u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .arm_pulse     (arm_pulse),
        .disarm_pulse  (disarm_pulse),
        .sr_load_pulse (sr_load_pulse),
        .sr_load_byte  (sr_load_byte),
        .mem_wr_pulse  (mem_wr_pulse),
        .mem_addr      (mem_addr),
        .cs_release    (cs_release),
        .wp_n          (wp_n),
        .status_byte   (status_byte),
        .mem_wr_ok     (mem_wr_ok),
        .sr_wr_ok      (sr_wr_ok)
    );

    // op codes: 0 idle, 1 arm, 2 disarm, 3 status load, 4 memory byte, 5 release
    // fields: op[32:30] data[29:22] addr[21:11] wp_n[10] mem_ok[9] sr_ok[8] status[7:0]
    localparam int NV = 23;
    localparam logic [32:0] VEC [NV] = '{
        {3'd0, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h00},
        {3'd4, 8'h00, 11'h123, 1'b1, 1'b0, 1'b0, 8'h00},
        {3'd3, 8'h8C, 11'h123, 1'b1, 1'b0, 1'b0, 8'h00},
        {3'd1, 8'h00, 11'h123, 1'b1, 1'b0, 1'b0, 8'h02},
        {3'd3, 8'h86, 11'h123, 1'b1, 1'b1, 1'b1, 8'h86},
        {3'd5, 8'h00, 11'h123, 1'b1, 1'b1, 1'b1, 8'h84},
        {3'd1, 8'h00, 11'h600, 1'b1, 1'b0, 1'b0, 8'h86},
        {3'd4, 8'h00, 11'h600, 1'b0, 1'b0, 1'b0, 8'h86},
        {3'd5, 8'h00, 11'h5FF, 1'b0, 1'b1, 1'b0, 8'h86},
        {3'd3, 8'h00, 11'h5FF, 1'b0, 1'b1, 1'b0, 8'h86},
        {3'd4, 8'h00, 11'h5FF, 1'b0, 1'b1, 1'b0, 8'h86},
        {3'd4, 8'h00, 11'h5FF, 1'b0, 1'b1, 1'b0, 8'h86},
        {3'd5, 8'h00, 11'h7FF, 1'b0, 1'b0, 1'b0, 8'h84},
        {3'd1, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h86},
        {3'd3, 8'h08, 11'h000, 1'b1, 1'b1, 1'b1, 8'h0A},
        {3'd0, 8'h00, 11'h400, 1'b0, 1'b0, 1'b1, 8'h0A},
        {3'd0, 8'h00, 11'h3FF, 1'b0, 1'b1, 1'b1, 8'h0A},
        {3'd2, 8'h00, 11'h3FF, 1'b1, 1'b1, 1'b1, 8'h08},
        {3'd1, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h0A},
        {3'd3, 8'hFF, 11'h000, 1'b1, 1'b1, 1'b1, 8'h8E},
        {3'd0, 8'h00, 11'h000, 1'b1, 1'b0, 1'b1, 8'h8E},
        {3'd5, 8'h00, 11'h000, 1'b1, 1'b0, 1'b1, 8'h8C},
        {3'd2, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h8C}
    };

    string vtag [NV] = '{
        "R1", "R9", "R6", "R2", "R5", "R10", "R2", "R7 R8", "R11", "R7",
        "R9", "R10", "R10 R8", "R2", "R5", "R7 R8", "R8", "R3", "R2",
        "R4 R5", "R8", "R10", "R3"
    };

    task automatic check_val(input string tag, input string what,
                             input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic clear_pulses();
        arm_pulse = 1'b0; disarm_pulse = 1'b0; sr_load_pulse = 1'b0;
        mem_wr_pulse = 1'b0; cs_release = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_val("R1", "status in reset", status_byte, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1", "status after reset", status_byte, 8'h00);
        check_val("R1", "mem permit after reset", {7'd0, mem_wr_ok}, 8'h00);
        check_val("R1", "status permit after reset", {7'd0, sr_wr_ok}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [32:0] v;
            v = VEC[i];
            clear_pulses();
            sr_load_byte = v[29:22];
            mem_addr     = v[21:11];
            wp_n         = v[10];
            unique case (v[32:30])
                3'd1: arm_pulse = 1'b1;
                3'd2: disarm_pulse = 1'b1;
                3'd3: sr_load_pulse = 1'b1;
                3'd4: mem_wr_pulse = 1'b1;
                3'd5: cs_release = 1'b1;
                default: ;
            endcase
            #1;
            check_val(vtag[i], $sformatf("vec %0d mem permit", i), {7'd0, mem_wr_ok}, {7'd0, v[9]});
            check_val(vtag[i], $sformatf("vec %0d status permit", i), {7'd0, sr_wr_ok}, {7'd0, v[8]});
            @(negedge clk);
            clear_pulses();
            #0.5;
            check_val(vtag[i], $sformatf("vec %0d status", i), status_byte, v[7:0]);
        end

        // R3: disarm beats arm in the same cycle (latch currently clear)
        arm_pulse = 1'b1; disarm_pulse = 1'b1;
        @(negedge clk);
        clear_pulses();
        check_val("R3", "arm+disarm together", status_byte, 8'h8C);

        // R3: disarm beats arm while armed
        arm_pulse = 1'b1;
        @(negedge clk);
        clear_pulses();
        check_val("R2", "arm again", status_byte, 8'h8E);
        arm_pulse = 1'b1; disarm_pulse = 1'b1;
        @(negedge clk);
        clear_pulses();
        check_val("R3", "arm+disarm while armed", status_byte, 8'h8C);

        // R1: reset mid-run returns to cleared state
        arm_pulse = 1'b1;
        @(negedge clk);
        clear_pulses();
        rst_n = 1'b0;
        #1;
        check_val("R1", "status under mid-run reset", status_byte, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1", "status after mid-run reset", status_byte, 8'h00);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule